// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Unit

This block sits next to the program counter and system-control registers of a simple in-order processor. It accepts a non-maskable interrupt request and steers execution to a fixed entry vector. It acts only at an instruction boundary, which the pipeline marks with a one-cycle strobe. No enable or mask bit can block the request.

When it takes the interrupt, the unit does four things on a single clock edge:
- It rewrites five fixed bits of the status word and leaves every other bit as it was.
- It loads the error-return PC. The value is the PC of the interrupted instruction, or the PC of the branch when that instruction sits in a branch delay slot.
- It loads the fetch PC with the entry vector.
- It raises a one-cycle redirect pulse so the fetch stage can follow.

The unit writes no cause code and saves no other state.

A request counts once per rising edge of the request line. Holding the line high does not cause further entries.

Top module: `nmi_entry_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, `redirect` is 0 and `status_out`, `error_pc` and `fetch_pc` are all 0.
- R2: No value of `status_in` can stop an entry. This includes a word with every interrupt-enable bit clear and a word whose error-level bit (bit 2) is already set.
- R3: A pending request is taken only on a cycle where `boundary` is 1. Until that cycle, `redirect` stays 0 however long the request waits.
- R4: Each 0-to-1 transition of `nmi_req` gives at most one entry. Holding the line at 1 over later boundaries gives no further entry. Several rising edges before one boundary collapse into a single entry. A rising edge seen in the same cycle as a boundary is taken in that cycle.
- R5: On entry, `status_out` equals `status_in` from the taking cycle with these bits forced: bit 22 = 1, bit 21 = 0, bit 20 = 0, bit 19 = 1, bit 2 = 1. All other bits are copied unchanged.
- R6: On entry, `error_pc` takes `branch_pc` if `in_delay_slot` was 1 in the taking cycle, and `restart_pc` otherwise.
- R7: On entry, `fetch_pc` becomes 0xBFC00000.
- R8: `redirect` is 1 for exactly the one cycle after the taking boundary. The new `status_out`, `error_pc` and `fetch_pc` are visible in that same cycle.
- R9: In cycles without an entry, `status_out` equals the previous cycle's `status_in` unchanged, and `error_pc` and `fetch_pc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable interrupt request level |
| boundary | input | 1 | One-cycle strobe marking an instruction boundary |
| restart_pc | input | 32 | PC of the instruction at the boundary |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| branch_pc | input | 32 | PC of the branch owning the delay slot |
| status_in | input | 32 | Current status word |
| status_out | output | 32 | Registered status word, rewritten on entry |
| error_pc | output | 32 | Error-return PC register |
| fetch_pc | output | 32 | New fetch PC after a redirect |
| redirect | output | 1 | One-cycle pulse requesting a fetch redirect |

## Verification
The entry path is driven with four status words:
- All zeros, which shows that every forced bit is set.
- All ones, which shows that bits 20 and 21 are cleared while the others survive.
- A word with only the two cleared bits and an enable bit set, which tells a clear apart from a pass-through.
- A mixed pattern, which catches shifted or swapped bit positions.

These status words are paired with alternating delay-slot flags and distinct branch and restart PCs, so that a swapped selection shows up. Directed cases cover a request that waits several cycles for a boundary, a line held high across boundaries, repeated edges that collapse into one entry, a rising edge that coincides with a boundary, and idle boundaries where the status word must pass through untouched.

// File: rtl/nmi_entry_pkg.sv
package nmi_entry_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ENTRY_VECTOR = 32'hBFC0_0000;

    // Status-word bit positions rewritten on entry
    localparam int ERR_LVL_BIT  = 2;
    localparam int NMI_FLAG_BIT = 19;
    localparam int SOFT_RST_BIT = 20;
    localparam int TLB_SHUT_BIT = 21;
    localparam int BOOT_VEC_BIT = 22;

    localparam word_t FORCE_ONE  = (word_t'(1) << BOOT_VEC_BIT)
                                 | (word_t'(1) << NMI_FLAG_BIT)
                                 | (word_t'(1) << ERR_LVL_BIT);
    localparam word_t FORCE_ZERO = (word_t'(1) << TLB_SHUT_BIT)
                                 | (word_t'(1) << SOFT_RST_BIT);

    typedef struct packed {
        logic  in_slot;
        word_t branch_pc;
        word_t restart_pc;
    } resume_ctx_t;

    typedef struct packed {
        word_t status;
        word_t err_pc;
        word_t fetch_pc;
    } entry_state_t;

    function automatic word_t resume_target(resume_ctx_t c);
        return c.in_slot ? c.branch_pc : c.restart_pc;
    endfunction

endpackage

// File: rtl/nmi_req_latch.sv
module nmi_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic boundary,
    output logic take
);
    logic req_d;
    logic pending;
    logic rise;

    assign rise = req & ~req_d;
    assign take = boundary & (pending | rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            pending <= 1'b0;
        end else begin
            req_d <= req;
            if (take)
                pending <= 1'b0;
            else if (rise)
                pending <= 1'b1;
        end
    end

    // R4
    pending_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !pending);

    // R3
    take_needs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary |-> !take);

endmodule

// File: rtl/nmi_status_fix.sv
module nmi_status_fix
    import nmi_entry_pkg::*;
(
    input  word_t status_in,
    output word_t status_nmi
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (FORCE_ONE[i]) begin : g_one
            assign status_nmi[i] = 1'b1;
        end else if (FORCE_ZERO[i]) begin : g_zero
            assign status_nmi[i] = 1'b0;
        end else begin : g_keep
            assign status_nmi[i] = status_in[i];
        end
    end
endmodule

// File: rtl/nmi_resume_sel.sv
module nmi_resume_sel
    import nmi_entry_pkg::*;
(
    input  resume_ctx_t ctx,
    output word_t       resume_pc
);
    assign resume_pc = resume_target(ctx);
endmodule

// File: rtl/nmi_entry_unit.sv
module nmi_entry_unit
    import nmi_entry_pkg::*;
#(
    parameter logic [31:0] VECTOR = ENTRY_VECTOR
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        nmi_req,
    input  logic        boundary,
    input  logic [31:0] restart_pc,
    input  logic        in_delay_slot,
    input  logic [31:0] branch_pc,
    input  logic [31:0] status_in,
    output logic [31:0] status_out,
    output logic [31:0] error_pc,
    output logic [31:0] fetch_pc,
    output logic        redirect
);
    logic         take;
    word_t        status_nmi;
    word_t        resume_pc;
    resume_ctx_t  ctx;
    entry_state_t st_q;
    entry_state_t st_d;
    logic         redirect_q;

    assign ctx = '{in_slot: in_delay_slot, branch_pc: branch_pc, restart_pc: restart_pc};

    nmi_req_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .req      (nmi_req),
        .boundary (boundary),
        .take     (take)
    );

    nmi_status_fix u_fix (
        .status_in  (status_in),
        .status_nmi (status_nmi)
    );

    nmi_resume_sel u_sel (
        .ctx       (ctx),
        .resume_pc (resume_pc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = status_in;
        if (take) begin
            st_d.status   = status_nmi;
            st_d.err_pc   = resume_pc;
            st_d.fetch_pc = VECTOR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            redirect_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            redirect_q <= take;
        end
    end

    assign status_out = st_q.status;
    assign error_pc   = st_q.err_pc;
    assign fetch_pc   = st_q.fetch_pc;
    assign redirect   = redirect_q;

    // R3
    redirect_after_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> $past(boundary));

    // R5
    status_bits_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (status_out[BOOT_VEC_BIT] && !status_out[TLB_SHUT_BIT]
                      && !status_out[SOFT_RST_BIT] && status_out[NMI_FLAG_BIT]
                      && status_out[ERR_LVL_BIT]));

    // R6
    resume_pick_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (error_pc == ($past(in_delay_slot) ? $past(branch_pc) : $past(restart_pc))));

    // R7
    vector_load_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (fetch_pc == VECTOR));

    // R9
    idle_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !$past(rst)) |-> (status_out == $past(status_in)
                                        && $stable(error_pc) && $stable(fetch_pc)));

endmodule

// File: tb/nmi_entry_unit_test.sv
module nmi_entry_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 1'b0;
    logic        boundary = 1'b0;
    logic [31:0] restart_pc = '0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] branch_pc = '0;
    logic [31:0] status_in = '0;
    logic [31:0] status_out, error_pc, fetch_pc;
    logic        redirect;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nmi_entry_unit uut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .boundary(boundary),
        .restart_pc(restart_pc), .in_delay_slot(in_delay_slot),
        .branch_pc(branch_pc), .status_in(status_in),
        .status_out(status_out), .error_pc(error_pc),
        .fetch_pc(fetch_pc), .redirect(redirect)
    );

    // vector: status_in, restart_pc, branch_pc, in_slot, expected status, expected epc
    typedef struct packed {
        logic [31:0] st;
        logic [31:0] rpc;
        logic [31:0] bpc;
        logic        slot;
        logic [31:0] exp_st;
        logic [31:0] exp_epc;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h8000_1000, 32'h8000_0FFC, 1'b0, 32'h0048_0004, 32'h8000_1000},
        '{32'hFFFF_FFFF, 32'h8000_2008, 32'h8000_2004, 1'b1, 32'hFFCF_FFFF, 32'h8000_2004},
        '{32'h0030_0001, 32'h0000_0400, 32'h0000_03FC, 1'b0, 32'h0048_0005, 32'h0000_0400},
        '{32'h1234_5678, 32'hA000_0014, 32'hA000_0010, 1'b1, 32'h124C_567C, 32'hA000_0010}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(); step();
        check("R1 redirect", {31'b0, redirect}, 32'h0);
        check("R1 status", status_out, 32'h0);
        check("R1 epc", error_pc, 32'h0);
        check("R1 fetch", fetch_pc, 32'h0);
        rst = 1'b0;
        step();
        check("R1 redirect after release", {31'b0, redirect}, 32'h0);

        // Table walk: R2 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            status_in = VECS[i].st; restart_pc = VECS[i].rpc;
            branch_pc = VECS[i].bpc; in_delay_slot = VECS[i].slot;
            nmi_req = 1'b1;
            step();
            boundary = 1'b1;
            step();
            boundary = 1'b0; nmi_req = 1'b0;
            check("R8 redirect", {31'b0, redirect}, 32'h1);
            check("R5 status", status_out, VECS[i].exp_st);
            check("R6 epc", error_pc, VECS[i].exp_epc);
            check("R7 fetch", fetch_pc, 32'hBFC0_0000);
            step();
            check("R8 single cycle", {31'b0, redirect}, 32'h0);
        end

        // R2: error level already set, enables clear
        status_in = 32'h0000_0004; restart_pc = 32'h1111_0000; in_delay_slot = 1'b0;
        nmi_req = 1'b1; boundary = 1'b1;
        step();
        boundary = 1'b0;
        check("R2 redirect with ERL set", {31'b0, redirect}, 32'h1);
        check("R4 same-cycle edge epc", error_pc, 32'h1111_0000);
        step();
        // R4: held high over boundaries -> no entry
        restart_pc = 32'h2222_0000;
        for (int k = 0; k < 2; k++) begin
            boundary = 1'b1; step(); boundary = 1'b0;
            check("R4 held high no redirect", {31'b0, redirect}, 32'h0);
            check("R4 held high epc kept", error_pc, 32'h1111_0000);
        end
        nmi_req = 1'b0;
        step();

        // R3: wait without boundary
        nmi_req = 1'b1; restart_pc = 32'h3333_0000;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3 no boundary no redirect", {31'b0, redirect}, 32'h0);
        end
        nmi_req = 1'b0;
        step(); step();
        check("R3 still waiting", {31'b0, redirect}, 32'h0);
        boundary = 1'b1; step(); boundary = 1'b0;
        check("R3 taken at boundary", {31'b0, redirect}, 32'h1);
        check("R3 epc", error_pc, 32'h3333_0000);

        // R4: several edges collapse to one entry
        step();
        nmi_req = 1'b1; step(); nmi_req = 1'b0; step();
        nmi_req = 1'b1; step(); nmi_req = 1'b0; step();
        restart_pc = 32'h4444_0000;
        boundary = 1'b1; step();
        check("R4 collapsed entry", {31'b0, redirect}, 32'h1);
        restart_pc = 32'h5555_0000;
        step(); boundary = 1'b0;
        check("R4 no second entry", {31'b0, redirect}, 32'h0);
        check("R4 epc from first", error_pc, 32'h4444_0000);

        // R9: idle pass-through
        status_in = 32'hDEAD_BEEF; boundary = 1'b1;
        step(); boundary = 1'b0;
        check("R9 status passthru", status_out, 32'hDEAD_BEEF);
        check("R9 fetch held", fetch_pc, 32'hBFC0_0000);
        check("R9 epc held", error_pc, 32'h4444_0000);
        status_in = 32'h0030_0000;
        step();
        check("R9 bits 20/21 kept when idle", status_out, 32'h0030_0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule